// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front End

This block is the register front end of a floppy disk controller. It sits on a synchronous, word-addressed bus. The register index is taken from four address bits that lie above a fixed shift, which gives sixteen slots. After reset it runs in a legacy soft-switch mode. In this mode every access, read or write, sets or clears one of eight single-bit latches, chosen only by the address. The latches are four stepper phases, motor, drive select, Q6 and Q7. A written byte is kept only when Q6 and Q7 are both set. In that case it goes to a data register if the motor latch is set, and to a mode register if it is not.

Bytes written to the legacy mode register also feed an unlock sequencer. When the sequencer sees its four-byte key, the block switches to an enhanced register layout and stays there until reset. In the enhanced layout, indices 0 to 7 are write ports and indices 8 to 15 are read ports. The implemented registers are:
- a phase register,
- a mode register with separate set and clear ports,
- a handshake read that reports sense when the phase register holds the drive-present query.

Read data is registered and appears one cycle after the read strobe.

Top module: `fdcRegFront`

## Requirements
- R1: After reset the block is in legacy mode (`enhancedMode`=0). `latches`, `enhModeReg`, `legData`, `legMode` and `rdData` are all 0.
- R2: The register index is `addr[12:9]`. In legacy mode, a read or a write of index n sets latch bit n>>1 to bit 0 of n. Latch bit positions are: 0 to 3 phases, 4 motor, 5 drive select, 6 Q6, 7 Q7.
- R3: In legacy mode every read returns 0 on `rdData` in the cycle after `rdEn`.
- R4: A legacy write takes effect when Q6 and Q7 are both 1, with each latch value taken after the access's own latch update. When the motor latch is 0, the byte goes to `legMode` and feeds the unlock sequencer.
  - The sequencer expects 0x57, 0x17, 0x57, 0x57, in that order.
  - A byte that does not match leaves the current step unchanged.
  - The fourth match sets `enhancedMode` in the next cycle and returns the sequencer to its first step.
- R5: An effective legacy write with the motor latch at 1 stores the byte in `legData` and does not advance the unlock sequencer.
- R6: A legacy write with Q6 or Q7 at 0 changes neither `legData`, `legMode` nor the mode.
- R7: Once enhanced, the block stays enhanced until reset, and accesses no longer change `latches`.
- R8: In enhanced mode, a write to index 4 stores the phase byte, and a read of index 12 returns it.
- R9: In enhanced mode, a write to index 6 clears the bits of `enhModeReg` that are 1 in the byte. A write to index 7 sets them.
- R10: In enhanced mode, a read of index 15 returns 0x08 when the phase byte is 0x77, and 0x00 otherwise.
- R11: In enhanced mode, reads of every index other than 12 and 15 return 0. Writes to indices other than 4, 6 and 7 change nothing.
- R12: `rdData` is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 13 | Byte address; bits 12:9 select the register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data, valid the cycle after `rdEn` |
| enhancedMode | output | 1 | 1 when the enhanced register layout is active |
| latches | output | 8 | Legacy soft-switch latch vector |
| legData | output | 8 | Legacy data register |
| legMode | output | 8 | Legacy mode register |
| enhModeReg | output | 8 | Enhanced mode register |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high in the same cycle. They also assume that the address bits below the index carry no meaning. The bench's access tasks drive exactly one strobe per cycle and leave the low address bits at zero. The Q6 and Q7 latches are set through read accesses before any write that is meant to take effect. The unlock key is tried with the motor latch on and with Q7 off before it is sent for real, with a non-matching byte inside it.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 8;
  localparam int LAT_N  = 8;
  localparam int LSEL_W = $clog2(LAT_N);

  // latch positions the control path decodes
  localparam int LAT_MOTOR = 4;
  localparam int LAT_Q6    = 6;
  localparam int LAT_Q7    = 7;

  // enhanced register indices
  localparam logic [IDX_W-1:0] IX_PHASE_WR = 4'd4;
  localparam logic [IDX_W-1:0] IX_MCLR_WR  = 4'd6;
  localparam logic [IDX_W-1:0] IX_MSET_WR  = 4'd7;
  localparam logic [IDX_W-1:0] IX_PHASE_RD = 4'd12;
  localparam logic [IDX_W-1:0] IX_HAND_RD  = 4'd15;

  localparam logic [DATA_W-1:0] KEY_A      = 8'h57;
  localparam logic [DATA_W-1:0] KEY_B      = 8'h17;
  localparam logic [DATA_W-1:0] QUERY_PRES = 8'h77;
  localparam logic [DATA_W-1:0] SENSE_BIT  = 8'h08;

  typedef enum logic [1:0] {RD_ZERO, RD_PHASE, RD_HAND} rdSel_e;

  typedef struct packed {
    logic              latchWr;
    logic [LSEL_W-1:0] latchSel;
    logic              latchVal;
    logic              dataWr;
    logic              legModeWr;
    logic              phaseWr;
    logic              modeClr;
    logic              modeSet;
    logic              rdValid;
    rdSel_e            rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/fdcRegCtrl.sv
module fdcRegCtrl
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              motorLat,
  input  logic              q6Lat,
  input  logic              q7Lat,
  output ctlStrobes_t       stb,
  output logic              enhanced
);
  logic [1:0]        step;
  logic [DATA_W-1:0] keyByte;
  logic              legacy, q6Eff, q7Eff, motEff, legWrEff, keyHit;
  logic [LSEL_W-1:0] sel;

  assign legacy = ~enhanced;
  assign sel    = idx[IDX_W-1:1];

  // latch values as they stand after this access has updated its own latch
  assign q6Eff  = (sel == LSEL_W'(LAT_Q6))    ? idx[0] : q6Lat;
  assign q7Eff  = (sel == LSEL_W'(LAT_Q7))    ? idx[0] : q7Lat;
  assign motEff = (sel == LSEL_W'(LAT_MOTOR)) ? idx[0] : motorLat;
  assign legWrEff = legacy & wrEn & q6Eff & q7Eff;

  always_comb begin
    case (step)
      2'd1:    keyByte = KEY_B;
      default: keyByte = KEY_A;
    endcase
  end

  assign keyHit = legWrEff & ~motEff & (wrData == keyByte);

  always_comb begin
    stb           = '0;
    stb.latchWr   = legacy & (wrEn | rdEn);
    stb.latchSel  = sel;
    stb.latchVal  = idx[0];
    stb.dataWr    = legWrEff & motEff;
    stb.legModeWr = legWrEff & ~motEff;
    stb.phaseWr   = enhanced & wrEn & (idx == IX_PHASE_WR);
    stb.modeClr   = enhanced & wrEn & (idx == IX_MCLR_WR);
    stb.modeSet   = enhanced & wrEn & (idx == IX_MSET_WR);
    stb.rdValid   = rdEn;
    if (enhanced && idx == IX_PHASE_RD)     stb.rdSel = RD_PHASE;
    else if (enhanced && idx == IX_HAND_RD) stb.rdSel = RD_HAND;
    else                                    stb.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step     <= 2'd0;
      enhanced <= 1'b0;
    end else if (keyHit) begin
      step <= step + 2'd1;          // wraps to 0 after the fourth match
      if (step == 2'd3) enhanced <= 1'b1;
    end
  end
endmodule

// File: rtl/fdcRegData.sv
module fdcRegData
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [LAT_N-1:0]  latches,
  output logic [DATA_W-1:0] legData,
  output logic [DATA_W-1:0] legMode,
  output logic [DATA_W-1:0] enhModeReg,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] phaseReg;
  logic [DATA_W-1:0] rdNext;

  generate
    for (genvar i = 0; i < LAT_N; i++) begin : g_lat
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latches[i] <= 1'b0;
        else if (stb.latchWr && stb.latchSel == LSEL_W'(i)) latches[i] <= stb.latchVal;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legData    <= '0;
      legMode    <= '0;
      phaseReg   <= '0;
      enhModeReg <= '0;
    end else begin
      if (stb.dataWr)    legData  <= wrData;
      if (stb.legModeWr) legMode  <= wrData;
      if (stb.phaseWr)   phaseReg <= wrData;
      if (stb.modeClr)   enhModeReg <= enhModeReg & ~wrData;
      else if (stb.modeSet) enhModeReg <= enhModeReg | wrData;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_PHASE: rdNext = phaseReg;
      RD_HAND:  rdNext = (phaseReg == QUERY_PRES) ? SENSE_BIT : '0;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdValid ? rdNext : '0;
  end
endmodule

// File: rtl/fdcRegFront.sv
module fdcRegFront
  import fdc_pkg::*;
#(
  parameter int SHIFT  = 9,
  localparam int ADDR_W = SHIFT + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              enhancedMode,
  output logic [LAT_N-1:0]  latches,
  output logic [DATA_W-1:0] legData,
  output logic [DATA_W-1:0] legMode,
  output logic [DATA_W-1:0] enhModeReg
);
  ctlStrobes_t      stb;
  logic [IDX_W-1:0] idx;
  logic             unusedLowAddr;

  assign idx           = addr[ADDR_W-1:SHIFT];
  assign unusedLowAddr = ^addr[SHIFT-1:0];

  fdcRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .idx(idx), .wrData(wrData),
    .motorLat(latches[LAT_MOTOR]), .q6Lat(latches[LAT_Q6]), .q7Lat(latches[LAT_Q7]),
    .stb(stb), .enhanced(enhancedMode)
  );

  fdcRegData u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .latches(latches),
    .legData(legData), .legMode(legMode), .enhModeReg(enhModeReg), .rdData(rdData)
  );
endmodule

// File: rtl/fdcRegFront_checker.sv
module fdcRegFront_checker
  import fdc_pkg::*;
#(
  parameter int SHIFT  = 9,
  localparam int ADDR_W = SHIFT + IDX_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              enhancedMode,
  input logic [LAT_N-1:0]  latches,
  input logic [DATA_W-1:0] enhModeReg
);
  logic [IDX_W-1:0] cIdx;
  assign cIdx = addr[ADDR_W-1:SHIFT];

  assert_latch_follows_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!enhancedMode && (wrEn || rdEn)) |=> latches[$past(cIdx[IDX_W-1:1])] == $past(cIdx[0]));

  assert_legacy_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!enhancedMode && rdEn) |=> rdData == '0);

  assert_enhanced_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    enhancedMode |=> enhancedMode);

  assert_latches_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    enhancedMode |=> $stable(latches));

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enhancedMode && wrEn && cIdx == IX_MCLR_WR) |=>
      enhModeReg == ($past(enhModeReg) & ~$past(wrData)));

  assert_mode_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enhancedMode && wrEn && cIdx == IX_MSET_WR) |=>
      enhModeReg == ($past(enhModeReg) | $past(wrData)));

  assert_handshake_values_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enhancedMode && rdEn && cIdx == IX_HAND_RD) |=> (rdData == '0 || rdData == SENSE_BIT));

  assert_legacy_mode_reg_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enhancedMode |-> enhModeReg == '0);

  assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == '0);
endmodule

bind fdcRegFront fdcRegFront_checker #(.SHIFT(SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .enhancedMode(enhancedMode), .latches(latches), .enhModeReg(enhModeReg)
);

// File: tb/fdcRegFront_bench.sv
`timescale 1ns/1ps
module fdcRegFront_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData, legData, legMode, enhModeReg, latches;
  logic        enhancedMode;

  fdcRegFront u_fdcRegFront (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .enhancedMode(enhancedMode), .latches(latches),
    .legData(legData), .legMode(legMode), .enhModeReg(enhModeReg)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [7:0] val; string tag; } expItem_t;
  expItem_t expQ[$];
  int checks = 0, fails = 0;
  logic [7:0] expLat = '0;
  logic expEnh = 1'b0;
  logic pendRd = 1'b0;
  bit done = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWr(int idx, logic [7:0] d);
    wrEn = 1'b1; addr = 13'(idx << 9); wrData = d;
    if (!expEnh) expLat[idx >> 1] = idx[0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRd(int idx, logic [7:0] exp, string tag);
    expItem_t it;
    it.val = exp; it.tag = tag;
    expQ.push_back(it);
    rdEn = 1'b1; addr = 13'(idx << 9);
    if (!expEnh) expLat[idx >> 1] = idx[0];
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: a read strobe seen at a rising edge has its data checked at the next falling edge
  always @(posedge clk) pendRd <= rdEn;
  always @(negedge clk) begin
    if (pendRd) begin
      if (expQ.size() == 0) chk("scoreboard-empty", rdData, 8'hxx);
      else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(it.tag, rdData, it.val);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic applyReset();
    rstN = 1'b0; expLat = '0; expEnh = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mode", {7'd0, enhancedMode}, 8'h00);
    chk("R1 latches", latches, 8'h00);
    chk("R1 enhModeReg", enhModeReg, 8'h00);
    chk("R1 legData", legData, 8'h00);
    chk("R1 legMode", legMode, 8'h00);
    chk("R1 rdData", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    applyReset();

    // R2 / R3: latches driven by address alone, legacy reads return 0
    doWr(1, 8'hAA); chk("R2 latch0 set", latches, expLat);
    doRd(3, 8'h00, "R3 legacy read"); chk("R2 latch1 via read", latches, expLat);
    doRd(9, 8'h00, "R3 legacy read motor"); chk("R2 motor on", latches, expLat);
    doWr(8, 8'h00); chk("R2 motor off", latches, 8'h03);

    // R6: Q7 clear, then Q6 set but Q7 clear: nothing sticks
    for (int i = 0; i < 4; i++) doWr(14, (i == 1) ? 8'h17 : 8'h57);
    for (int i = 0; i < 4; i++) doWr(13, (i == 1) ? 8'h17 : 8'h57);
    chk("R6 legData untouched", legData, 8'h00);
    chk("R6 legMode untouched", legMode, 8'h00);
    chk("R6 still legacy", {7'd0, enhancedMode}, 8'h00);

    // R5: motor on, key sent to Q7H goes to data register only
    doRd(9, 8'h00, "R3 legacy read motor2");
    doWr(15, 8'h57); doWr(15, 8'h17); doWr(15, 8'h57); doWr(15, 8'h3C);
    chk("R5 legData", legData, 8'h3C);
    chk("R5 legMode untouched", legMode, 8'h00);
    chk("R5 still legacy", {7'd0, enhancedMode}, 8'h00);
    chk("R2 latches after R5", latches, expLat);

    // R4: motor off via index 8 (Q6,Q7 still set) starts the key; mismatch holds step
    doWr(8, 8'h57); chk("R4 first key to legMode", legMode, 8'h57);
    doWr(15, 8'h99); chk("R4 mismatch to legMode", legMode, 8'h99);
    doWr(15, 8'h17);
    doWr(15, 8'h57); chk("R4 not yet enhanced", {7'd0, enhancedMode}, 8'h00);
    doWr(15, 8'h57); expEnh = 1'b1;
    chk("R4 enhanced after fourth", {7'd0, enhancedMode}, 8'h01);
    chk("R5 legData kept", legData, 8'h3C);

    // R7: latches frozen in enhanced mode
    doRd(1, 8'h00, "R11 read index1");
    doWr(3, 8'hFF); doWr(10, 8'h00);
    chk("R7 latches frozen", latches, expLat);

    // R8 / R10: phase and handshake
    doWr(4, 8'h5A);
    doRd(12, 8'h5A, "R8 phase readback");
    doRd(15, 8'h00, "R10 handshake no query");
    doWr(4, 8'h77);
    doRd(15, 8'h08, "R10 handshake sense");
    doRd(12, 8'h77, "R8 phase readback 77");

    // R9: set and clear ports
    doWr(7, 8'hF0); chk("R9 set", enhModeReg, 8'hF0);
    doWr(6, 8'h30); chk("R9 clear", enhModeReg, 8'hC0);
    doWr(7, 8'h05); chk("R9 set again", enhModeReg, 8'hC5);
    doWr(6, 8'h00); chk("R9 clear none", enhModeReg, 8'hC5);

    // R11: other writes ignored, other reads zero
    doWr(0, 8'hFF); doWr(1, 8'hFF); doWr(2, 8'hFF); doWr(3, 8'hFF); doWr(5, 8'hFF);
    doWr(12, 8'h00); doWr(15, 8'h00);
    chk("R11 enhModeReg kept", enhModeReg, 8'hC5);
    doRd(12, 8'h77, "R11 phase kept");
    for (int i = 8; i < 15; i++) if (i != 12) doRd(i, 8'h00, "R11 other read");
    doRd(0, 8'h00, "R11 write index read");

    // R12: idle cycles read 0
    @(negedge clk); chk("R12 idle rdData", rdData, 8'h00);
    chk("R7 still enhanced", {7'd0, enhancedMode}, 8'h01);

    // R1 again after a second reset
    applyReset();
    doRd(12, 8'h00, "R3 legacy read after reset");
    chk("R2 latch after reset", latches, expLat);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule